// File: doc/BRIEF.md
# Two-Stage Fetch Front End with Jump Squash

This block is the front end of a two-stage in-order processor. It owns a word-addressed program counter and drives it straight to an external instruction memory. That memory answers within the same cycle. The block captures the returned 32-bit word in a pipeline register, and that register feeds the execute stage. Decode, execute and write-back all happen together in the second stage, so the pipeline needs no data-hazard logic.

The execute stage reports two things: whether its current instruction is a jump that was taken, and the target of that jump. The word fetched during that same cycle is on the wrong path. The block drops it by steering an all-zero nop into the pipeline register instead. A jump that is not taken squashes nothing. After reset the pipeline register holds the nop, so execute spends one cycle idle at startup. Apart from that startup cycle and the one cycle lost after each taken jump, the program runs as it would on a single-cycle machine.

Top module: `fetch_frontend`

## Requirements
- R1: While rst_ni is low, imem_addr_o is 0 and inst_ex_o is 0x00000000, and both take these values as soon as reset is asserted, without waiting for a clock edge.
- R2: On a rising clock edge with jump_taken_i low, imem_addr_o becomes its previous value plus one.
- R3: On a rising clock edge with jump_taken_i low, inst_ex_o becomes the imem_rdata_i value present just before that edge.
- R4: On a rising clock edge with jump_taken_i high, inst_ex_o becomes 0x00000000, whatever imem_rdata_i holds.
- R5: On a rising clock edge with jump_taken_i high, imem_addr_o becomes jump_target_i.
- R6: While jump_taken_i is low, jump_target_i has no effect on imem_addr_o or inst_ex_o.
- R7: The program counter is AW bits wide. Stepping past the all-ones address wraps it to 0.
- R8: In the first cycle after reset is released, execute sees the nop. The word at address 0 reaches inst_ex_o after the first rising edge.
- R9: In closed loop, the instruction that follows a taken jump in memory never reaches inst_ex_o, and the jump target follows the nop. A not-taken jump lets the next sequential instruction through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| imem_addr_o | output | AW | Word address sent to instruction memory |
| imem_rdata_i | input | 32 | Instruction word returned for imem_addr_o |
| jump_taken_i | input | 1 | Execute stage holds a jump that was taken |
| jump_target_i | input | AW | Word address of the taken jump's target |
| inst_ex_o | output | 32 | Instruction presented to the execute stage |

## Verification
The bench goes after three kinds of corner case.

- **Squash path.** A design that only reloads the PC on a jump would let the wrong-path word execute once. A design that squashes on any jump would lose the instruction after a not-taken jump. The closed-loop run places one taken and one not-taken jump in memory and watches for both faults.
- **Target leaking and wrap-around.** A design that loads the target without checking the taken flag would jump when it should not, so the bench drives junk targets while jump_taken_i is low. A PC with the wrong width or a saturating counter would fail the all-ones-to-zero step.
- **Reset.** A synchronous reset would leave stale outputs until the next edge. A wrong startup order would put the first fetch into execute one cycle early.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
  localparam int unsigned INST_W = 32;
  typedef logic [INST_W-1:0] inst_t;
  localparam inst_t NOP_WORD = '0;
endpackage

// File: rtl/fetch_pc_gen.sv
module fetch_pc_gen #(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          jump_taken_i,
  input  logic [AW-1:0] jump_target_i,
  output logic [AW-1:0] pc_o
);
  localparam logic [AW-1:0] PC_RST  = '0;
  localparam logic [AW-1:0] PC_STEP = AW'(1);

  logic [AW-1:0] pc_q, pc_d, pc_seq;

  assign pc_seq = pc_q + PC_STEP;

  always_comb begin
    pc_d = pc_seq;
    if (jump_taken_i) pc_d = jump_target_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pc_q <= PC_RST;
    else         pc_q <= pc_d;
  end

  assign pc_o = pc_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_taken_i |=> pc_q == AW'($past(pc_q) + 1)) else $error("pc step");  // R2
  AST_PC_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!jump_taken_i && pc_q == '1) |=> pc_q == '0) else $error("pc wrap");  // R7
  AST_PC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_taken_i |=> pc_q == $past(jump_target_i)) else $error("pc load");  // R5
  AST_PC_RST: assert property (@(posedge clk_i)
    !rst_ni |=> pc_q == '0) else $error("pc reset");  // R1
endmodule

// File: rtl/fetch_kill_mux.sv
module fetch_kill_mux
  import fetch_pkg::*;
(
  input  logic  kill_i,
  input  inst_t fetched_i,
  output inst_t inst_o
);
  assign inst_o = kill_i ? NOP_WORD : fetched_i;
endmodule

// File: rtl/fetch_inst_reg.sv
module fetch_inst_reg
  import fetch_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  inst_t inst_d_i,
  output inst_t inst_q_o
);
  inst_t inst_q;

  // reset value is the nop: execute idles for one startup cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) inst_q <= NOP_WORD;
    else         inst_q <= inst_d_i;
  end

  assign inst_q_o = inst_q;

  AST_IR_RST: assert property (@(posedge clk_i)
    !rst_ni |=> inst_q == NOP_WORD) else $error("ir reset");  // R1
endmodule

// File: rtl/fetch_frontend.sv
module fetch_frontend
  import fetch_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [AW-1:0] imem_addr_o,
  input  logic [31:0]   imem_rdata_i,
  input  logic          jump_taken_i,
  input  logic [AW-1:0] jump_target_i,
  output logic [31:0]   inst_ex_o
);
  inst_t ir_d;

  fetch_pc_gen #(.AW(AW)) u_pc_gen (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .jump_taken_i  (jump_taken_i),
    .jump_target_i (jump_target_i),
    .pc_o          (imem_addr_o)
  );

  fetch_kill_mux u_kill_mux (
    .kill_i    (jump_taken_i),
    .fetched_i (imem_rdata_i),
    .inst_o    (ir_d)
  );

  fetch_inst_reg u_inst_reg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inst_d_i (ir_d),
    .inst_q_o (inst_ex_o)
  );

  AST_KILL_NOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    jump_taken_i |=> inst_ex_o == NOP_WORD) else $error("kill");  // R4
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_taken_i |=> inst_ex_o == $past(imem_rdata_i)) else $error("pass");  // R3
  AST_TARGET_IGNORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !jump_taken_i |=> imem_addr_o != $past(jump_target_i) || $past(jump_target_i) == AW'($past(imem_addr_o) + 1))
    else $error("target leak");  // R6
endmodule

// File: tb/fetch_frontend_tb.sv
module fetch_frontend_tb;
  localparam int unsigned AW = 10;
  localparam int unsigned NV = 14;
  localparam logic [AW-1:0] PC_MAX = '1;
  // each entry: {jump_taken, jump_target}
  localparam logic [AW:0] VEC [NV] = '{
    {1'b0, 10'h000}, {1'b0, 10'h2AB}, {1'b0, 10'h155}, {1'b1, 10'h100},
    {1'b0, 10'h3C3}, {1'b1, 10'h3FF}, {1'b0, 10'h0F0}, {1'b0, 10'h000},
    {1'b1, 10'h3FE}, {1'b0, 10'h000}, {1'b0, 10'h111}, {1'b1, 10'h000},
    {1'b1, 10'h007}, {1'b0, 10'h000}
  };

  logic          clk = 1'b0;
  logic          rst_ni = 1'b0;
  logic [AW-1:0] imem_addr;
  logic [31:0]   imem_rdata;
  logic          jump_taken;
  logic [AW-1:0] jump_target;
  logic [31:0]   inst_ex;
  logic          closed_loop = 1'b0;
  logic          vec_jt = 1'b0;
  logic [AW-1:0] vec_tgt = '0;
  int            n_chk = 0;
  int            n_fail = 0;

  always #5 clk = ~clk;

  // program: addr 5 holds a taken jump to 16, addr 20 a not-taken jump
  function automatic logic [31:0] mem_word(input logic [AW-1:0] a);
    if (closed_loop && a == 10'd5)  return 32'hF800_0010;
    if (closed_loop && a == 10'd20) return 32'hF000_0030;
    return {8'h5A, 14'd0, a};
  endfunction

  assign imem_rdata  = mem_word(imem_addr);
  assign jump_taken  = closed_loop ? (inst_ex[31:28] == 4'hF && inst_ex[27]) : vec_jt;
  assign jump_target = closed_loop ? inst_ex[AW-1:0] : vec_tgt;

  fetch_frontend #(.AW(AW)) u_dut (
    .clk_i         (clk),
    .rst_ni        (rst_ni),
    .imem_addr_o   (imem_addr),
    .imem_rdata_i  (imem_rdata),
    .jump_taken_i  (jump_taken),
    .jump_target_i (jump_target),
    .inst_ex_o     (inst_ex)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
    finish_run();
  end

  initial begin
    logic [AW-1:0] m_pc;
    logic [31:0]   m_inst;
    logic          seen_wrong, seen_fall, seen_tgt, kill_ok, prev_jump;

    // R1 reset state
    repeat (3) @(negedge clk);
    check("R1", 32'(imem_addr), 32'd0);
    check("R1", inst_ex, 32'd0);
    rst_ni = 1'b1;
    // R8 startup: execute sees the nop, word 0 arrives after one edge
    check("R8", inst_ex, 32'd0);
    @(negedge clk);
    check("R8", inst_ex, mem_word('0));
    check("R2", 32'(imem_addr), 32'd1);

    // vector table walk
    m_pc = imem_addr;
    for (int i = 0; i < NV; i++) begin
      vec_jt  = VEC[i][AW];
      vec_tgt = VEC[i][AW-1:0];
      m_inst  = vec_jt ? 32'd0 : mem_word(m_pc);
      @(negedge clk);
      if (VEC[i][AW]) begin
        check("R5", 32'(imem_addr), 32'(VEC[i][AW-1:0]));
        check("R4", inst_ex, m_inst);
        m_pc = VEC[i][AW-1:0];
      end else begin
        if (m_pc == PC_MAX)          check("R7", 32'(imem_addr), 32'd0);
        else if (VEC[i][AW-1:0] != 0) check("R6", 32'(imem_addr), 32'(AW'(m_pc + 1)));
        else                          check("R2", 32'(imem_addr), 32'(AW'(m_pc + 1)));
        check("R3", inst_ex, m_inst);
        m_pc = AW'(m_pc + 1);
      end
    end
    vec_jt = 1'b0;

    // R1 asynchronous reset mid-cycle
    #2 rst_ni = 1'b0;
    #1;
    check("R1", 32'(imem_addr), 32'd0);
    check("R1", inst_ex, 32'd0);

    // R9 closed loop with execute-driven jumps
    closed_loop = 1'b1;
    @(negedge clk);
    rst_ni = 1'b1;
    seen_wrong = 1'b0; seen_fall = 1'b0; seen_tgt = 1'b0; kill_ok = 1'b1; prev_jump = 1'b0;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (prev_jump && inst_ex !== 32'd0) kill_ok = 1'b0;
      prev_jump = (inst_ex == 32'hF800_0010);
      if (inst_ex == mem_word(10'd6))  seen_wrong = 1'b1;
      if (inst_ex == mem_word(10'd21)) seen_fall  = 1'b1;
      if (inst_ex == mem_word(10'd16)) seen_tgt   = 1'b1;
    end
    check("R9", 32'(seen_wrong), 32'd0);
    check("R9", 32'(kill_ok), 32'd1);
    check("R9", 32'(seen_tgt), 32'd1);
    check("R9", 32'(seen_fall), 32'd1);
    finish_run();
  end
endmodule